// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is an I2C target that controls a four-way downstream bus switch. It samples SCL and SDA with the system clock and finds START and STOP conditions. It answers one 7-bit address, built from a fixed upper nibble of binary 1110 and three strap inputs. Each byte a host writes after the address goes into an eight-bit control register, and a host read returns that register.

The low bits of the control register say which downstream channels are connected. The enable outputs do not follow a write straight away. They copy the register only when a STOP condition appears, so a connection is made only once the bus has gone idle with both lines high. A repeated START leaves the enables as they are.

The enable vector stands in for the physical pass switches. The analog path, pull-ups and clock stretching are not part of this block.

Top module: `i2c_chsel_switch`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {1110, strap[2:0]}, by pulling SDA low for the whole high phase of the ninth clock. Bit 0 of the address byte selects the direction, 1 for a read and 0 for a write.
- R2: For any other address the block leaves SDA released on the ninth clock. It then neither acknowledges nor stores any byte until the next START or STOP.
- R3: After its address is acknowledged for a write, every data byte is acknowledged and stored in the control register. When several bytes arrive in one transfer, the register holds the last one.
- R4: The channel enables do not change between STOPs, whatever writes happen in between.
- R5: When a STOP is detected, chan_en[n] takes bit n of the control register, for n = 0 to 3. Any combination of channels, including none and all four, can be enabled.
- R6: Bits 7 to 4 of a written byte never reach chan_en. They are still stored and read back.
- R7: A read returns the full control register, MSB first. While the host acknowledges, the register is sent again. After the host withholds its acknowledge, the block stops driving SDA.
- R8: A repeated START, with no STOP in between, does not copy a newly written byte to the enables.
- R9: A synchronous reset clears the control register and all channel enables to zero and releases SDA.
- R10: The block starts pulling SDA low only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| strap | input | 3 | Strap inputs that give the low three address bits |
| sda_oe | output | 1 | When 1, the open-drain driver pulls SDA low |
| chan_en | output | 4 | Active channel enables, bit n for channel n |

## Verification
The hardest situation to reach from the ports is a pending selection whose commit must wait. The block has to hold a written byte, keep the old enables through a repeated START and a complete read of the new value, and change only at the final STOP. A directed sequence sets up exactly that chain. The random transfers then mix matching and non-matching addresses, one to three bytes per write, transfers left open and continued after a repeated START, and multi-byte reads. A bench model of both the control register and the active enables predicts every acknowledge bit, every read byte and the enables before and after each STOP.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL/SDA into the clk domain and flags edges and bus conditions.
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_q, sda_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) begin
               scl_sh[0] <= 1'b1;
               sda_sh[0] <= 1'b1;
            end else begin
               scl_sh[0] <= scl_i;
               sda_sh[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) begin
               scl_sh[i] <= 1'b1;
               sda_sh[i] <= 1'b1;
            end else begin
               scl_sh[i] <= scl_sh[i-1];
               sda_sh[i] <= sda_sh[i-1];
            end
         end
      end
   end

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_chsel_engine.sv
// Bit-level target engine: address match, write capture, read shift-out.
module i2c_chsel_engine
   import i2c_chsel_pkg::*;
#(
   parameter int                 STRAP_W    = 3,
   parameter logic [6-STRAP_W:0] ADDR_FIXED = 4'b1110
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [STRAP_W-1:0] strap,
   input  logic [7:0]         rd_data,
   output logic               sda_oe,
   output logic               wr_stb,
   output logic [7:0]         wr_data,
   output bus_state_t         state
);
   localparam int         BYTE_W   = 8;
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   logic [BYTE_W-1:0] sh;
   logic [3:0]        cnt;
   logic              rw;
   logic              host_ack;

   assign wr_data = sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         sh       <= '0;
         cnt      <= '0;
         sda_oe   <= 1'b0;
         rw       <= 1'b0;
         wr_stb   <= 1'b0;
         host_ack <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise && cnt < LAST_BIT) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (sh[BYTE_W-1:1] == {ADDR_FIXED, strap}) begin
                           sda_oe <= 1'b1;
                           rw     <= sh[0];
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state  <= ST_IGNORE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        wr_stb <= 1'b1;
                        state  <= ST_WACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        state  <= ST_RDATA;
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        state  <= ST_WDATA;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RACK;
                     end else begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        state  <= ST_RDATA;
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/chsel_regs.sv
// Control register plus the active enables committed at STOP.
module chsel_regs #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [NUM_CH-1:0] chan_en
);
   always_ff @(posedge clk) begin
      if (rst)         ctrl_q <= '0;
      else if (wr_stb) ctrl_q <= wr_data;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      always_ff @(posedge clk) begin
         if (rst)         chan_en[c] <= 1'b0;
         else if (commit) chan_en[c] <= ctrl_q[c];
      end
   end
endmodule

// File: rtl/i2c_chsel_switch.sv
module i2c_chsel_switch
   import i2c_chsel_pkg::*;
#(
   parameter int                 NUM_CH      = 4,
   parameter int                 STRAP_W     = 3,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [6-STRAP_W:0] ADDR_FIXED  = 4'b1110
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap,
   output logic               sda_oe,
   output logic [NUM_CH-1:0]  chan_en
);
   localparam int DATA_W = 8;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and the byte width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("STRAP_W must lie between 1 and 6");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic wr_stb;
   logic [DATA_W-1:0] wr_data, ctrl_q;
   bus_state_t state;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_chsel_engine #(.STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED)) u_eng (
      .clk       (clk),
      .rst       (rst),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap     (strap),
      .rd_data   (ctrl_q),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .state     (state)
   );

   chsel_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .commit  (stop_det),
      .ctrl_q  (ctrl_q),
      .chan_en (chan_en)
   );
endmodule

// File: rtl/i2c_chsel_checker.sv
module i2c_chsel_checker
   import i2c_chsel_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              stop_det,
   input logic              scl_s,
   input logic              sda_oe,
   input logic [7:0]        ctrl_q,
   input logic [NUM_CH-1:0] chan_en,
   input bus_state_t        state
);
   // R4: enables hold unless a STOP was seen
   a_r4_hold_between_stops: assert property (@(posedge clk) disable iff (rst)
      !stop_det |=> $stable(chan_en));

   // R5: at STOP the enables take the low bits of the control register
   a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
      stop_det |=> chan_en == $past(ctrl_q[NUM_CH-1:0]));

   // R9: reset clears register, enables and the SDA driver
   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> (chan_en == '0 && ctrl_q == 8'h00 && !sda_oe));

   // R10: SDA pull-down begins only while SCL is low
   a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
      $rose(sda_oe) |-> !scl_s);

   // R2: a target that is ignoring the bus never drives SDA
   a_r2_ignore_silent: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_chsel_switch i2c_chsel_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .stop_det (stop_det),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe),
   .ctrl_q   (ctrl_q),
   .chan_en  (chan_en),
   .state    (state)
);

// File: tb/tb_i2c_chsel_switch.sv
`timescale 1ns/1ps
module tb_i2c_chsel_switch;
   localparam int Q        = 8;
   localparam int WD_LIMIT = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic h_scl = 1'b1, h_sda = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       sda_oe;
   logic [3:0] chan_en;
   wire        sda_bus = h_sda & ~sda_oe;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [7:0] m_ctrl = 8'h00;
   logic [3:0] m_en   = 4'h0;

   always #2.5 clk = ~clk;

   i2c_chsel_switch dut (
      .clk     (clk),
      .rst     (rst),
      .scl_i   (h_scl),
      .sda_i   (sda_bus),
      .strap   (strap),
      .sda_oe  (sda_oe),
      .chan_en (chan_en)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic bit f_match(input logic [6:0] a, input logic [2:0] s);
      return a == {4'b1110, s};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      h_sda = 1'b1; wq(Q);
      h_scl = 1'b1; wq(Q);
      h_sda = 1'b0; wq(Q);
      h_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      h_sda = 1'b0; wq(Q);
      h_scl = 1'b1; wq(Q);
      h_sda = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         h_sda = b[i]; wq(Q);
         h_scl = 1'b1; wq(Q);
         h_scl = 1'b0; wq(Q);
      end
      h_sda = 1'b1; wq(Q);
      h_scl = 1'b1; wq(Q/2);
      acked = !sda_bus;
      wq(Q/2);
      h_scl = 1'b0; wq(Q);
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         wq(Q);
         h_scl = 1'b1; wq(Q/2);
         b[i] = sda_bus;
         wq(Q/2);
         h_scl = 1'b0;
      end
      wq(Q);
      h_sda = !give_ack; wq(Q);
      h_scl = 1'b1; wq(Q);
      h_scl = 1'b0; wq(Q);
      h_sda = 1'b1;
   endtask

   // Write transfer; optionally ends with a STOP.
   task automatic wr_txn(input logic [6:0] a, input int n,
                         input logic [7:0] d [4], input bit do_stop);
      bit ack;
      bit m = f_match(a, strap);
      bus_start();
      send_byte({a, 1'b0}, ack);
      if (m) chk(ack == 1'b1, "R1 address ack", ack, 1);
      else   chk(ack == 1'b0, "R2 foreign address nack", ack, 0);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], ack);
         if (m) begin
            chk(ack == 1'b1, "R3 data ack", ack, 1);
            m_ctrl = d[k];
         end else begin
            chk(ack == 1'b0, "R2 data ignored", ack, 0);
         end
      end
      chk(chan_en == m_en, "R4 enables held before STOP", chan_en, m_en);
      if (do_stop) begin
         bus_stop();
         wq(4);
         m_en = m_ctrl[3:0];
         chk(chan_en == m_en, "R5 R6 enables after STOP", chan_en, m_en);
      end
   endtask

   // Read transfer of n bytes, host NACKs the last one, then STOP.
   task automatic rd_txn(input int n, input bit do_start_only);
      bit ack;
      logic [7:0] b;
      bus_start();
      send_byte({4'b1110, strap, 1'b1}, ack);
      chk(ack == 1'b1, "R1 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         read_byte(k != n - 1, b);
         chk(b == m_ctrl, "R7 read data", b, m_ctrl);
      end
      wq(2);
      chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
      chk(chan_en == m_en, "R8 enables held until STOP", chan_en, m_en);
      if (!do_start_only) begin
         bus_stop();
         wq(4);
         m_en = m_ctrl[3:0];
         chk(chan_en == m_en, "R5 enables after read STOP", chan_en, m_en);
      end
   endtask

   initial begin
      logic [7:0] d [4];
      logic [6:0] a;
      int n;
      void'($urandom(32'h1A2B3C));
      wq(6);
      chk(chan_en == 4'h0, "R9 reset enables", chan_en, 0);
      chk(sda_oe == 1'b0, "R9 reset SDA released", sda_oe, 0);
      rst = 1'b0;
      wq(4);

      // single byte, one channel pattern
      d = '{8'h05, 8'h00, 8'h00, 8'h00};
      wr_txn({4'b1110, strap}, 1, d, 1'b1);

      // several bytes: last wins, upper nibble set
      d = '{8'h0A, 8'hF3, 8'h6C, 8'h00};
      wr_txn({4'b1110, strap}, 3, d, 1'b1);
      rd_txn(1, 1'b0);   // R6: upper bits read back

      // foreign address: nothing stored
      d = '{8'hFF, 8'h0F, 8'h00, 8'h00};
      wr_txn({4'b1110, strap ^ 3'b010}, 2, d, 1'b1);
      wr_txn(7'h25, 1, d, 1'b1);
      rd_txn(1, 1'b0);

      // repeated START then read: enables wait for the STOP (R8)
      d = '{8'h0F, 8'h00, 8'h00, 8'h00};
      wr_txn({4'b1110, strap}, 1, d, 1'b0);
      rd_txn(2, 1'b1);
      bus_stop();
      wq(4);
      m_en = m_ctrl[3:0];
      chk(chan_en == 4'hF, "R8 R5 commit at final STOP", chan_en, 4'hF);

      // none enabled, upper bits only (R6)
      d = '{8'hF0, 8'h00, 8'h00, 8'h00};
      wr_txn({4'b1110, strap}, 1, d, 1'b1);
      chk(chan_en == 4'h0, "R6 upper nibble ignored", chan_en, 0);
      rd_txn(3, 1'b0);

      // reset in the middle of a transfer
      d = '{8'h09, 8'h00, 8'h00, 8'h00};
      wr_txn({4'b1110, strap}, 1, d, 1'b1);
      d = '{8'h06, 8'h00, 8'h00, 8'h00};
      wr_txn({4'b1110, strap}, 1, d, 1'b0);
      h_scl = 1'b1; h_sda = 1'b1;
      rst = 1'b1; wq(3);
      rst = 1'b0; wq(3);
      m_ctrl = 8'h00; m_en = 4'h0;
      chk(chan_en == 4'h0, "R9 mid-transfer reset", chan_en, 0);
      rd_txn(1, 1'b0);

      // constrained random transfers
      for (int it = 0; it < 40; it++) begin
         if (($urandom % 8) == 0) strap = 3'($urandom);
         if (($urandom % 4) != 0) a = {4'b1110, strap};
         else begin
            a = 7'($urandom);
            while (f_match(a, strap)) a = 7'($urandom);
         end
         n = 1 + ($urandom % 3);
         for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
         if (($urandom % 3) == 0) begin
            wr_txn(a, n, d, 1'b0);
            rd_txn(1 + ($urandom % 2), 1'b0);
         end else begin
            wr_txn(a, n, d, 1'b1);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule